// File: doc/BRIEF.md
# PME Wake Event Sequencer

This block turns a device wake event into the correct power-management wake signal for a function in a low-power state. It keeps the two software-visible wake bits (enable and a sticky status flag), checks whether the current device power state has wake support in a capability word, and then picks one of two delivery paths.

While main power is present (states D1, D2 and D3hot), the wake is delivered as an in-band message that carries the function's requester ID. Such a message may leave only while the link is in L0. If the link is not in L0, the block first asks the link controller to leave L1 and waits for L0. When main power is gone (D3cold) and auxiliary power is present, no in-band traffic is possible. The block then pulls an active-low sideband wake pin low and holds it there until main power returns.

A single message is sent per wake event. Further events are ignored until software clears the status flag by writing a 1 to it.

Top module: `pme_wake_seq`

## Requirements
- R1: After reset the enable and status bits read 0, `wake_n` is 1, and `msg_send` and `req_l1_exit` are 0.
- R2: `csr_rdata` shows the current power state in bits [1:0] (0=D0, 1=D1, 2=D2, 3=D3hot), the enable in bit 8 and the status in bit 15, with all other bits 0. A config write while `d3cold` is 0 loads the enable from `cfg_wdata` bit 8.
- R3: A wake event is accepted when all of the following hold: enable is 1, status is 0, and the active state has wake support. Support comes from `pm_cap` bit 11 for D1, bit 12 for D2, bit 14 for D3hot, and bit 15 together with `aux_pwr` for D3cold. Acceptance sets status in the next cycle.
- R4: Status stays set until a config write with `cfg_wdata` bit 15 = 1. A write with bit 15 = 0 leaves it unchanged. An acceptance in the same cycle as a clearing write wins.
- R5: An accepted in-band wake with `link_l0` high pulses `msg_send` for exactly the next cycle, with `msg_rid` equal to `req_id`.
- R6: An accepted in-band wake with `link_l0` low raises `req_l1_exit` from the next cycle until the cycle after `link_l0` is first sampled high. `msg_send` then pulses in that cycle, and it is only ever high while `link_l0` is high.
- R7: Only one message is sent per accepted event. Wake events that arrive while status is set produce no message.
- R8: An accepted wake in D3cold drives `wake_n` low from the next cycle, sends no message and requests no L1 exit. `wake_n` returns high the cycle after `d3cold` falls.
- R9: A wake event in D0, with enable 0, or in a state whose support bit is 0, changes no status and produces no message, no exit request and no `wake_n` assertion.
- R10: In D3cold without `aux_pwr`, a wake event has no effect.
- R11: Config writes are ignored while `d3cold` is 1.
- R12: The enable and status bits keep their values across power state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wake_evt | input | 1 | Wake event pulse from device logic |
| dstate | input | 2 | Power state while main power is on |
| d3cold | input | 1 | Main power removed |
| aux_pwr | input | 1 | Auxiliary supply present |
| link_l0 | input | 1 | Link is in L0 |
| pm_cap | input | CSR_W | Capability word holding per-state wake support bits |
| cfg_wr | input | 1 | Config write strobe to the control/status word |
| cfg_wdata | input | CSR_W | Config write data |
| csr_rdata | output | CSR_W | Control/status read value |
| req_id | input | RID_W | Function requester ID |
| req_l1_exit | output | 1 | Request to leave L1 |
| msg_send | output | 1 | One-cycle wake message strobe |
| msg_rid | output | RID_W | Requester ID carried by the message |
| wake_n | output | 1 | Active-low sideband wake pin |

## Verification
Wake events are applied in each of D0, D1, D2, D3hot and D3cold. This separates per-state gating from a single global enable, and the support word deliberately lacks the D2 bit. In-band wakes are tried both with the link already in L0 and with it held out of L0 for several cycles. This tells the immediate-send path apart from the exit-then-send path. Repeated wakes before and after a status clear, and clearing writes with bit 15 at 0 and at 1, separate one-shot delivery from re-arming. Power loss with and without auxiliary supply, plus writes attempted during D3cold, expose the sideband path and the write lockout.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int EN_POS  = 8;
  localparam int ST_POS  = 15;
  localparam int CAP_D1  = 11;
  localparam int CAP_D2  = 12;
  localparam int CAP_D3H = 14;
  localparam int CAP_D3C = 15;

  typedef enum logic [1:0] {DS_D0 = 2'd0, DS_D1 = 2'd1, DS_D2 = 2'd2, DS_D3HOT = 2'd3} dstate_e;
  typedef enum logic [1:0] {TX_IDLE, TX_EXIT, TX_SEND} tx_state_e;

  // wake support for the active state; D3cold overrides dstate
  function automatic logic wake_supported(input logic sup_d1, input logic sup_d2,
                                          input logic sup_d3h, input logic sup_d3c,
                                          input logic [1:0] ds, input logic cold,
                                          input logic aux);
    logic s;
    if (cold) s = sup_d3c & aux;
    else begin
      case (dstate_e'(ds))
        DS_D1:    s = sup_d1;
        DS_D2:    s = sup_d2;
        DS_D3HOT: s = sup_d3h;
        default:  s = 1'b0;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/pme_csr.sv
module pme_csr (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic wr_st_bit,
  input  logic set_st,
  output logic en_q,
  output logic st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wr_en_bit;
      if (set_st) st_q <= 1'b1;
      else if (wr_en && wr_st_bit) st_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pme_gate.sv
module pme_gate (
  input  logic       wake_evt,
  input  logic       en_q,
  input  logic       st_q,
  input  logic       supported,
  input  logic       cold,
  output logic       wake_accept,
  output logic       inband_go,
  output logic       oob_go
);
  always_comb begin
    wake_accept = wake_evt & en_q & ~st_q & supported;
    inband_go   = wake_accept & ~cold;
    oob_go      = wake_accept & cold;
  end
endmodule

// File: rtl/pme_inband_tx.sv
module pme_inband_tx import pme_pkg::*; #(
  parameter int RID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cold,
  input  logic             link_l0,
  input  logic [RID_W-1:0] req_id,
  output logic             req_l1_exit,
  output logic             msg_send,
  output logic [RID_W-1:0] msg_rid
);
  tx_state_e        st_q;
  logic [RID_W-1:0] rid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      rid_q <= '0;
    end else if (cold) begin
      st_q <= TX_IDLE;
    end else begin
      case (st_q)
        TX_IDLE: if (go) begin
          rid_q <= req_id;
          st_q  <= link_l0 ? TX_SEND : TX_EXIT;
        end
        TX_EXIT: if (link_l0) st_q <= TX_SEND;
        TX_SEND: if (link_l0) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign req_l1_exit = (st_q == TX_EXIT);
  assign msg_send    = (st_q == TX_SEND) & link_l0;
  assign msg_rid     = rid_q;
endmodule

// File: rtl/pme_wake_pin.sv
module pme_wake_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cold,
  output logic wake_n
);
  logic drive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     drive_q <= 1'b0;
    else if (!cold) drive_q <= 1'b0;
    else if (go)    drive_q <= 1'b1;
  end
  assign wake_n = ~drive_q;
endmodule

// File: rtl/pme_wake_seq.sv
module pme_wake_seq import pme_pkg::*; #(
  parameter int RID_W = 16,
  parameter int CSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_evt,
  input  logic [1:0]       dstate,
  input  logic             d3cold,
  input  logic             aux_pwr,
  input  logic             link_l0,
  input  logic [CSR_W-1:0] pm_cap,
  input  logic             cfg_wr,
  input  logic [CSR_W-1:0] cfg_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic [RID_W-1:0] req_id,
  output logic             req_l1_exit,
  output logic             msg_send,
  output logic [RID_W-1:0] msg_rid,
  output logic             wake_n
);
  localparam logic [CSR_W-1:0] CAP_MASK = (CSR_W'(1) << CAP_D1) | (CSR_W'(1) << CAP_D2) |
                                          (CSR_W'(1) << CAP_D3H) | (CSR_W'(1) << CAP_D3C);
  localparam logic [CSR_W-1:0] WR_MASK  = (CSR_W'(1) << EN_POS) | (CSR_W'(1) << ST_POS);

  // named internal events, observed by the bound checker
  logic en_q, st_q, supported, cfg_take;
  logic wake_accept, inband_go, oob_go;
  logic unused_cap, unused_wdata;

  assign unused_cap   = ^(pm_cap & ~CAP_MASK);
  assign unused_wdata = ^(cfg_wdata & ~WR_MASK);

  assign cfg_take  = cfg_wr & ~d3cold;
  assign supported = wake_supported(pm_cap[CAP_D1], pm_cap[CAP_D2], pm_cap[CAP_D3H],
                                    pm_cap[CAP_D3C], dstate, d3cold, aux_pwr);

  pme_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_take),
    .wr_en_bit(cfg_wdata[EN_POS]), .wr_st_bit(cfg_wdata[ST_POS]),
    .set_st(wake_accept), .en_q(en_q), .st_q(st_q)
  );

  pme_gate u_gate (
    .wake_evt(wake_evt), .en_q(en_q), .st_q(st_q), .supported(supported),
    .cold(d3cold), .wake_accept(wake_accept), .inband_go(inband_go), .oob_go(oob_go)
  );

  pme_inband_tx #(.RID_W(RID_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(inband_go), .cold(d3cold), .link_l0(link_l0),
    .req_id(req_id), .req_l1_exit(req_l1_exit), .msg_send(msg_send), .msg_rid(msg_rid)
  );

  pme_wake_pin u_pin (
    .clk(clk), .rst_n(rst_n), .go(oob_go), .cold(d3cold), .wake_n(wake_n)
  );

  always_comb begin
    csr_rdata         = '0;
    csr_rdata[1:0]    = dstate;
    csr_rdata[EN_POS] = en_q;
    csr_rdata[ST_POS] = st_q;
  end
endmodule

// File: rtl/pme_wake_seq_chk.sv
module pme_wake_seq_chk #(
  parameter int CSR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wake_evt,
  input logic [1:0]       dstate,
  input logic             d3cold,
  input logic             link_l0,
  input logic             cfg_wr,
  input logic [CSR_W-1:0] cfg_wdata,
  input logic             req_l1_exit,
  input logic             msg_send,
  input logic             wake_n,
  input logic             wake_accept,
  input logic             st_q
);
  assert_accept_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_accept |=> st_q);

  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !(cfg_wr && !d3cold && cfg_wdata[15])) |=> st_q);

  assert_msg_only_in_l0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_send |-> link_l0);

  assert_no_msg_during_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_l1_exit |-> !msg_send);

  assert_single_msg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_send |=> !msg_send);

  assert_pin_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(d3cold) |=> wake_n);

  assert_pin_excludes_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_n |-> !msg_send && !req_l1_exit);

  assert_d0_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && dstate == 2'd0 && !d3cold) |-> !wake_accept);
endmodule

bind pme_wake_seq pme_wake_seq_chk #(.CSR_W(CSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .dstate(dstate), .d3cold(d3cold),
  .link_l0(link_l0), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .req_l1_exit(req_l1_exit),
  .msg_send(msg_send), .wake_n(wake_n), .wake_accept(wake_accept), .st_q(st_q)
);

// File: tb/test_pme_wake_seq.sv
module test_pme_wake_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_evt = 1'b0;
  logic [1:0]  dstate = 2'd0;
  logic        d3cold = 1'b0;
  logic        aux_pwr = 1'b0;
  logic        link_l0 = 1'b1;
  logic [15:0] pm_cap = 16'hC800;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] req_id = 16'h3A5C;
  logic [15:0] csr_rdata, msg_rid;
  logic        req_l1_exit, msg_send, wake_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pme_wake_seq i_pme_wake_seq (
    .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .dstate(dstate), .d3cold(d3cold),
    .aux_pwr(aux_pwr), .link_l0(link_l0), .pm_cap(pm_cap), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .csr_rdata(csr_rdata), .req_id(req_id),
    .req_l1_exit(req_l1_exit), .msg_send(msg_send), .msg_rid(msg_rid), .wake_n(wake_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---- behavioural reference model ----
  bit m_en, m_st, m_pin, m_wait_l0;
  int m_owed;  // messages owed to the link
  bit ok_state;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_st = 0; m_pin = 0; m_owed = 0; m_wait_l0 = 0;
    end else begin
      if (d3cold) ok_state = pm_cap[15] && aux_pwr;
      else if (dstate == 2'd1) ok_state = pm_cap[11];
      else if (dstate == 2'd2) ok_state = pm_cap[12];
      else if (dstate == 2'd3) ok_state = pm_cap[14];
      else ok_state = 0;
      if (m_owed > 0 && !m_wait_l0 && link_l0) m_owed--;
      else if (m_wait_l0 && link_l0) m_wait_l0 = 0;
      if (!d3cold) m_pin = 0;
      if (d3cold) begin m_owed = 0; m_wait_l0 = 0; end
      if (wake_evt && m_en && !m_st && ok_state) begin
        if (d3cold) m_pin = 1;
        else begin m_owed = 1; m_wait_l0 = !link_l0; end
        m_st = 1;
      end else if (cfg_wr && !d3cold && cfg_wdata[15]) m_st = 0;
      if (cfg_wr && !d3cold) m_en = cfg_wdata[8];
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R2 rdata", csr_rdata, {m_st, 6'b0, m_en, 6'b0, dstate});
      chk("R5 msg_send", {15'b0, msg_send}, {15'b0, (m_owed > 0 && !m_wait_l0 && link_l0)});
      if (msg_send) chk("R5 msg_rid", msg_rid, req_id);
      chk("R6 req_l1_exit", {15'b0, req_l1_exit}, {15'b0, m_wait_l0});
      chk("R8 wake_n", {15'b0, wake_n}, {15'b0, !m_pin});
    end
  end

  // ---- stimulus helpers: drive at negedge, observe after the edge ----
  task automatic drive_wake();
    @(negedge clk); wake_evt = 1;
    @(posedge clk); #3;
    @(negedge clk); wake_evt = 0;
  endtask

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk); cfg_wr = 1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0; cfg_wdata = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 rdata", csr_rdata, 16'h0000);
    chk("R1 wake_n", {15'b0, wake_n}, 16'h1);
    chk("R1 msg_send", {15'b0, msg_send}, 16'h0);
    chk("R1 req_l1_exit", {15'b0, req_l1_exit}, 16'h0);
    rst_n = 1;
    idle(2);

    // enable, then wake in D0: ignored
    cfg_write(16'h0100);
    chk("R2 enable readback", csr_rdata, 16'h0100);
    drive_wake(); idle(2);
    chk("R9 D0 wake ignored", csr_rdata, 16'h0100);

    // D1 with link in L0: immediate message
    @(negedge clk); dstate = 2'd1; wake_evt = 1;
    @(posedge clk); #3;
    chk("R5 msg pulse", {15'b0, msg_send}, 16'h1);
    chk("R5 rid", msg_rid, 16'h3A5C);
    chk("R3 status set", csr_rdata, 16'h8101);
    @(negedge clk); wake_evt = 0;
    @(posedge clk); #3;
    chk("R5 single pulse", {15'b0, msg_send}, 16'h0);
    // repeat wake with status set: nothing
    @(negedge clk); wake_evt = 1;
    @(posedge clk); #3;
    chk("R7 no resend", {15'b0, msg_send}, 16'h0);
    @(negedge clk); wake_evt = 0;
    idle(2);
    cfg_write(16'h0100);
    chk("R4 write of 0 keeps status", csr_rdata, 16'h8101);
    cfg_write(16'h8100);
    chk("R4 write of 1 clears status", csr_rdata, 16'h0101);

    // D3hot with link in L1: exit first
    @(negedge clk); dstate = 2'd3; link_l0 = 0; wake_evt = 1;
    @(posedge clk); #3;
    chk("R6 exit request", {15'b0, req_l1_exit}, 16'h1);
    chk("R6 no early msg", {15'b0, msg_send}, 16'h0);
    @(negedge clk); wake_evt = 0;
    idle(3);
    chk("R6 still waiting", {15'b0, req_l1_exit}, 16'h1);
    link_l0 = 1;
    @(posedge clk); #3;
    chk("R6 msg after L0", {15'b0, msg_send}, 16'h1);
    chk("R6 exit dropped", {15'b0, req_l1_exit}, 16'h0);
    idle(2);
    cfg_write(16'h8100);

    // D2 unsupported
    @(negedge clk); dstate = 2'd2;
    drive_wake(); idle(2);
    chk("R9 unsupported state", csr_rdata, 16'h0102);

    // disabled in D1
    cfg_write(16'h0000);
    @(negedge clk); dstate = 2'd1;
    drive_wake(); idle(2);
    chk("R9 disabled", csr_rdata, 16'h0001);
    cfg_write(16'h0100);

    // D3cold without aux, then with aux
    @(negedge clk); dstate = 2'd3; d3cold = 1; aux_pwr = 0;
    drive_wake(); idle(2);
    chk("R10 no aux status", csr_rdata, 16'h0103);
    chk("R10 no aux pin", {15'b0, wake_n}, 16'h1);
    @(negedge clk); aux_pwr = 1; wake_evt = 1;
    @(posedge clk); #3;
    chk("R8 pin low", {15'b0, wake_n}, 16'h0);
    chk("R8 no msg", {15'b0, msg_send}, 16'h0);
    @(negedge clk); wake_evt = 0;
    cfg_write(16'h8000);
    chk("R11 write ignored in cold", csr_rdata, 16'h8103);
    idle(3);
    chk("R8 pin held", {15'b0, wake_n}, 16'h0);
    @(negedge clk); d3cold = 0; dstate = 2'd0;
    @(posedge clk); #3;
    chk("R8 pin released", {15'b0, wake_n}, 16'h1);
    chk("R12 bits retained", csr_rdata, 16'h8100);

    // clear and wake in the same cycle: set wins
    @(negedge clk); dstate = 2'd1;
    cfg_write(16'h8100);
    @(negedge clk); wake_evt = 1; cfg_wr = 1; cfg_wdata = 16'h8100;
    @(posedge clk); #3;
    chk("R4 set beats clear", csr_rdata, 16'h8101);
    @(negedge clk); wake_evt = 0; cfg_wr = 0; cfg_wdata = 0;
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule